// File: doc/BRIEF.md
# Serial-Number Arbitrated Bus ID Assigner

This block is the slave-side logic that lets many identical devices on a two-wire serial bus each receive a unique 8-bit bus ID. The bus master sends one broadcast command that carries an offered ID. Every unassigned device answers by shifting out its own fixed 48-bit serial number onto the open-drain data line. A device that drives a one but sees the line held at zero drops out at once. The one device that completes its whole serial number keeps the offered ID, and only when the master closes the command correctly. The master repeats the command until no device answers.

The block runs on a system clock. It takes the filtered SCL and SDA levels and single-cycle START and STOP strobes from a separate line conditioner. It drives a pull-down enable for SDA, a pull-down enable for an external-select line, and the current ID. A second command byte returns the ID to 00h so that assignment can be run again.

Top module: `aa_id_assigner`

## Requirements
- R1: After reset the ID is 00h, and neither SDA nor the select line is pulled.
- R2: An unassigned device acknowledges (pulls SDA low during the ninth clock) a command byte whose upper nibble is 0110 and whose low three bits are 100, sent MSB first. Bit 3 of that byte is the select-enable flag. The device also acknowledges the ID byte that follows.
- R3: After the ID byte, the device sends its 48-bit serial number MSB first as six bytes. It changes its SDA drive only while SCL is low, pulls low for a 0 bit, releases for a 1 bit, and releases the line during each master acknowledge slot.
- R4: If the device releases SDA for a 1 bit and samples SDA low on the SCL rising edge, it stops transmitting for the rest of the command and takes no ID.
- R5: A device that sent all 48 bits, then saw a no-acknowledge (SDA high) after the sixth byte followed by STOP, loads the offered ID on that STOP and not earlier.
- R6: A STOP anywhere else in the command ends it with no ID change, and SDA and the select line are released.
- R7: A master acknowledge after the sixth serial byte, or a no-acknowledge after any of the first five, aborts the command with no ID change and SDA released.
- R8: Once an ID is held, assign command bytes are not acknowledged and the ID keeps its value.
- R9: A command byte with upper nibble 0110 and low three bits 011 (bit 3 ignored) is acknowledged in any state. At the end of its acknowledge slot the ID returns to 00h and assign commands are accepted again.
- R10: With the select-enable flag set, the select line is pulled from the end of the ID byte's acknowledge slot until the command ends, aborts or is lost. With the flag clear it is never pulled.
- R11: A command byte that matches neither code is not acknowledged and the rest of the command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| scl | input | 1 | Filtered serial clock level |
| sda | input | 1 | Filtered serial data level as seen on the bus |
| start_det | input | 1 | One-cycle strobe: START condition seen |
| stop_det | input | 1 | One-cycle strobe: STOP condition seen |
| sda_pull | output | 1 | Pull SDA low when 1 |
| eds_pull | output | 1 | Pull the external-select line low when 1 |
| id_q | output | 8 | Current bus ID |

## Verification
SCL edges are found by comparing the input with a registered copy. Every SDA drive change therefore lands on the first clock edge that sees the new SCL level, and the ID change lands on the edge that samples the STOP strobe (or, for the clear code, the first edge after the acknowledge clock falls). The bench holds each SCL phase for four clocks and reads the wired-AND bus at the middle of the high phase, several edges after any drive change. Checks on the ID and select line are taken two clock cycles after the last SCL edge or strobe. A competing device is modelled in the bench with its own serial number and its own drop-out rule, so the bits read back and the winner come from the arbitration rule alone.

// File: rtl/aa_pkg.sv
// Shared constants, state and command types for the bus ID assigner.
package aa_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] CMD_FAMILY  = 4'b0110;
    localparam logic [2:0] ASSIGN_TAIL = 3'b100;
    localparam logic [2:0] CLEAR_TAIL  = 3'b011;

    typedef enum logic [2:0] {ST_IDLE, ST_CTRL, ST_ID, ST_SER, ST_FIN} st_e;
    typedef enum logic [1:0] {CMD_NONE, CMD_ASSIGN, CMD_CLEAR} cmd_e;

    // Classify a received command byte; assign only counts while unassigned.
    function automatic cmd_e decode_cmd(input logic [BYTE_W-1:0] b, input logic taken);
        if (b[7:4] != CMD_FAMILY)               return CMD_NONE;
        if (b[2:0] == ASSIGN_TAIL && !taken)    return CMD_ASSIGN;
        if (b[2:0] == CLEAR_TAIL)               return CMD_CLEAR;
        return CMD_NONE;
    endfunction
endpackage

// File: rtl/aa_scl_edges.sv
// Finds SCL rising and falling edges in the system clock domain.
// Assumes scl is already synchronised and filtered; idle bus level is high.
module aa_scl_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    output logic rise,
    output logic fall
);
    logic scl_q;

    // Hold the previous SCL level.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl;
    end

    assign rise = scl & ~scl_q;
    assign fall = ~scl & scl_q;
endmodule

// File: rtl/aa_sn_shift.sv
// Holds the fixed serial number and presents it one bit at a time, MSB first.
// Assumes load and shift never fire in the same cycle.
module aa_sn_shift #(
    parameter int                SN_W   = 48,
    parameter logic [SN_W-1:0]   SERIAL = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic shift,
    output logic msb
);
    logic [SN_W-1:0] sh;

    // Reload the serial number or advance one bit.
    always_ff @(posedge clk) begin
        if (!rst_n || load) sh <= SERIAL;
        else if (shift)     sh <= {sh[SN_W-2:0], 1'b0};
    end

    assign msb = sh[SN_W-1];
endmodule

// File: rtl/aa_id_assigner.sv
// Slave-side ID assignment by serial-number arbitration on a two-wire bus.
// Decodes the assign and clear command bytes, acknowledges them, shifts out
// the serial number with wired-AND arbitration and commits the offered ID on
// a correctly placed STOP. Assumes START/STOP strobes come from an external
// line conditioner and that each SCL phase lasts several clk cycles.
module aa_id_assigner
    import aa_pkg::*;
#(
    parameter int                SN_W   = 48,
    parameter logic [SN_W-1:0]   SERIAL = 48'h9C5A_3B71_E2D4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull,
    output logic              eds_pull,
    output logic [BYTE_W-1:0] id_q
);
    localparam int SN_BYTES = SN_W / BYTE_W;
    localparam int BC_W     = $clog2(SN_BYTES);
    localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(SN_BYTES - 1);

    logic              scl_rise, scl_fall;
    logic              sn_bit, sn_load, sn_shift;
    st_e               st;
    cmd_e              cmd_q, cmd_now;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] rx_sh, offered;
    logic [BC_W-1:0]   byte_cnt;
    logic              oe_q, assigned;

    aa_scl_edges u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .scl  (scl),
        .rise (scl_rise),
        .fall (scl_fall)
    );

    aa_sn_shift #(.SN_W(SN_W), .SERIAL(SERIAL)) u_sn (
        .clk  (clk),
        .rst_n(rst_n),
        .load (sn_load),
        .shift(sn_shift),
        .msb  (sn_bit)
    );

    // Classify the byte just received and steer the serial shifter.
    always_comb begin
        cmd_now  = decode_cmd(rx_sh, assigned);
        sn_load  = scl_fall && (st == ST_ID) && (bitcnt == 4'd8);
        sn_shift = scl_rise && (st == ST_SER) && (bitcnt < 4'd8);
    end

    // Command sequencer: byte framing, acknowledge, arbitration and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cmd_q    <= CMD_NONE;
            bitcnt   <= '0;
            rx_sh    <= '0;
            offered  <= '0;
            byte_cnt <= '0;
            oe_q     <= 1'b0;
            assigned <= 1'b0;
            sda_pull <= 1'b0;
            eds_pull <= 1'b0;
            id_q     <= '0;
        end else if (start_det) begin
            st       <= ST_CTRL;
            cmd_q    <= CMD_NONE;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
            eds_pull <= 1'b0;
        end else if (stop_det) begin
            if (st == ST_FIN) begin
                id_q     <= offered;
                assigned <= 1'b1;
            end
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
            eds_pull <= 1'b0;
        end else begin
            case (st)
                ST_CTRL, ST_ID: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt < 4'd8) rx_sh <= {rx_sh[BYTE_W-2:0], sda};
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        if (st == ST_ID) begin
                            offered  <= rx_sh;
                            sda_pull <= 1'b1;
                        end else if (cmd_now == CMD_NONE) begin
                            st <= ST_IDLE;
                        end else begin
                            cmd_q    <= cmd_now;
                            oe_q     <= rx_sh[3];
                            sda_pull <= 1'b1;
                        end
                    end else if (scl_fall && bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if (st == ST_ID) begin
                            st       <= ST_SER;
                            byte_cnt <= '0;
                            sda_pull <= ~sn_bit;
                            eds_pull <= oe_q;
                        end else begin
                            sda_pull <= 1'b0;
                            if (cmd_q == CMD_CLEAR) begin
                                id_q     <= '0;
                                assigned <= 1'b0;
                                st       <= ST_IDLE;
                            end else begin
                                st <= ST_ID;
                            end
                        end
                    end
                end
                ST_SER: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt < 4'd8) begin
                            if (sn_bit && !sda) begin
                                st       <= ST_IDLE;
                                sda_pull <= 1'b0;
                                eds_pull <= 1'b0;
                            end
                        end else if ((byte_cnt == LAST_BYTE) ? !sda : sda) begin
                            st       <= ST_IDLE;
                            eds_pull <= 1'b0;
                        end else if (byte_cnt == LAST_BYTE) begin
                            st <= ST_FIN;
                        end
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_pull <= 1'b0;
                        end else if (bitcnt == 4'd9) begin
                            bitcnt   <= '0;
                            byte_cnt <= byte_cnt + BC_W'(1);
                            sda_pull <= ~sn_bit;
                        end else begin
                            sda_pull <= ~sn_bit;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/aa_id_assigner_chk.sv
// Port-level properties of the bus ID assigner, bound to the top module.
module aa_id_assigner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_pull,
    input logic       eds_pull,
    input logic [7:0] id_q
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (id_q == 8'h00 && !sda_pull && !eds_pull));

    assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> (!$past(scl) || $past(start_det) || $past(stop_det)));

    assert_id_changes_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(id_q) |-> ($past(stop_det) || id_q == 8'h00));

    assert_stop_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_pull && !eds_pull));

    assert_eds_only_unassigned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eds_pull |-> id_q == 8'h00);
endmodule

bind aa_id_assigner aa_id_assigner_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_pull (sda_pull),
    .eds_pull (eds_pull),
    .id_q     (id_q)
);

// File: tb/aa_id_assigner_tb.sv
module aa_id_assigner_tb;
    localparam logic [47:0] MY_SN = 48'h9C5A_3B71_E2D4;
    localparam int HP = 4;
    localparam logic [7:0] CLR_BYTE = 8'b0110_0_011;

    typedef struct packed {
        logic        oe;
        logic [7:0]  offer;
        logic        comp_en;
        logic [47:0] comp_sn;
        logic        win;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{1'b0, 8'h3C, 1'b0, 48'h0000_0000_0000, 1'b1},
        '{1'b1, 8'h5A, 1'b1, 48'hFFFF_FFFF_FFFF, 1'b1},
        '{1'b1, 8'h21, 1'b1, 48'h1234_5678_9ABC, 1'b0},
        '{1'b1, 8'h77, 1'b1, 48'h9C5A_3B71_E2D5, 1'b1},
        '{1'b0, 8'h88, 1'b1, 48'h9C5A_3B71_E2D0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, comp_pull = 1'b0;
    logic start_det = 1'b0, stop_det = 1'b0;
    logic sda_pull, eds_pull, bus_sda, done = 1'b0;
    logic [7:0] id_q;
    int n_chk = 0, n_err = 0;

    always #5 clk = ~clk;
    assign bus_sda = m_sda & ~sda_pull & ~comp_pull;

    aa_id_assigner #(.SN_W(48), .SERIAL(MY_SN)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(bus_sda),
        .start_det(start_det), .stop_det(stop_det),
        .sda_pull(sda_pull), .eds_pull(eds_pull), .id_q(id_q)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SCL pulse: drive during low, sample bus in middle of high.
    task automatic clk_bit(input logic m, input logic c, output logic seen);
        m_sda = m; comp_pull = c;
        wait_cyc(HP);
        scl = 1'b1;
        wait_cyc(HP / 2);
        seen = bus_sda;
        wait_cyc(HP / 2);
        scl = 1'b0;
    endtask

    task automatic do_start();
        comp_pull = 1'b0; m_sda = 1'b1; scl = 1'b1;
        wait_cyc(HP);
        m_sda = 1'b0; start_det = 1'b1;
        wait_cyc(1);
        start_det = 1'b0;
        wait_cyc(HP);
        scl = 1'b0;
    endtask

    task automatic do_stop();
        comp_pull = 1'b0; m_sda = 1'b0;
        wait_cyc(HP);
        scl = 1'b1;
        wait_cyc(HP);
        m_sda = 1'b1; stop_det = 1'b1;
        wait_cyc(1);
        stop_det = 1'b0;
        wait_cyc(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, s);
        clk_bit(1'b1, 1'b0, s);
        acked = !s;
    endtask

    // Clock serial bytes with an optional competitor; master nacks at byte nack_at.
    task automatic read_ser(input logic [47:0] csn, input logic cen, input int nbytes,
                            input int nack_at, output logic [47:0] rx);
        logic act, s, cb;
        act = cen; rx = '0;
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 7; i >= 0; i--) begin
                cb = csn[(5 - b) * 8 + i];
                clk_bit(1'b1, act & ~cb, s);
                if (act && cb && !s) act = 1'b0;
                rx = {rx[46:0], s};
            end
            clk_bit((b == nack_at) ? 1'b1 : 1'b0, 1'b0, s);
        end
    endtask

    task automatic run_assign(input logic oe, input logic [7:0] offer, output logic a1, output logic a2);
        do_start();
        send_byte({4'b0110, oe, 3'b100}, a1);
        send_byte(offer, a2);
    endtask

    task automatic do_clear(output logic a);
        do_start();
        send_byte(CLR_BYTE, a);
        wait_cyc(2);
        do_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic a1, a2;
        logic [47:0] rx;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 id after reset", id_q, 8'h00);
        chk("R1 sda after reset", sda_pull, 1'b0);
        chk("R1 eds after reset", eds_pull, 1'b0);

        // Table walk: one assign command per entry, from an unassigned state.
        for (int v = 0; v < 5; v++) begin
            do_clear(a1);
            run_assign(VECS[v].oe, VECS[v].offer, a1, a2);
            chk("R2 assign byte ack", a1, 1'b1);
            chk("R2 id byte ack", a2, 1'b1);
            read_ser(VECS[v].comp_sn, VECS[v].comp_en, 6, 5, rx);
            wait_cyc(2);
            chk("R3 serial bits on bus", rx, VECS[v].win ? MY_SN : VECS[v].comp_sn);
            chk("R10 eds before stop", eds_pull, VECS[v].oe & VECS[v].win);
            chk("R5 no id before stop", id_q, 8'h00);
            if (!VECS[v].win) chk("R4 released after loss", sda_pull, 1'b0);
            do_stop();
            chk("R5 R4 id after stop", id_q, VECS[v].win ? VECS[v].offer : 8'h00);
            chk("R10 eds after stop", eds_pull, 1'b0);
        end

        // R8: assigned device ignores assign.
        run_assign(1'b0, 8'hC3, a1, a2);
        read_ser('0, 1'b0, 6, 5, rx);
        do_stop();
        chk("R5 directed assign", id_q, 8'hC3);
        do_start();
        send_byte({4'b0110, 1'b1, 3'b100}, a1);
        chk("R8 no ack when assigned", a1, 1'b0);
        chk("R8 sda released", sda_pull, 1'b0);
        wait_cyc(2);
        chk("R8 eds stays off", eds_pull, 1'b0);
        do_stop();
        chk("R8 id kept", id_q, 8'hC3);

        // R9: clear with bit 3 set, then assign accepted again.
        do_start();
        send_byte(8'b0110_1_011, a1);
        wait_cyc(2);
        chk("R9 clear acked", a1, 1'b1);
        chk("R9 id cleared", id_q, 8'h00);
        do_stop();
        run_assign(1'b0, 8'h19, a1, a2);
        chk("R9 assign accepted after clear", a1, 1'b1);
        do_stop();
        chk("R6 stop after id byte", id_q, 8'h00);

        // R11: other bytes ignored.
        do_start();
        send_byte(8'b0110_0_111, a1);
        chk("R11 wrong tail no ack", a1, 1'b0);
        send_byte(8'h42, a2);
        chk("R11 rest ignored", a2, 1'b0);
        do_stop();
        do_start();
        send_byte(8'b1110_0_100, a1);
        chk("R11 wrong family no ack", a1, 1'b0);
        do_stop();

        // R6: STOP in mid serial number.
        run_assign(1'b1, 8'h44, a1, a2);
        read_ser('0, 1'b0, 3, 9, rx);
        wait_cyc(2);
        chk("R10 eds during serial", eds_pull, 1'b1);
        do_stop();
        chk("R6 id after early stop", id_q, 8'h00);
        chk("R6 sda released", sda_pull, 1'b0);
        chk("R6 eds released", eds_pull, 1'b0);

        // R7: ack after last byte aborts.
        run_assign(1'b0, 8'h66, a1, a2);
        read_ser('0, 1'b0, 6, 9, rx);
        do_stop();
        chk("R7 ack on last byte", id_q, 8'h00);

        // R7: nack after second byte aborts; third byte reads released bus.
        run_assign(1'b0, 8'h67, a1, a2);
        read_ser('0, 1'b0, 3, 1, rx);
        chk("R7 released after early nack", rx[23:0], {MY_SN[47:32], 8'hFF});
        do_stop();
        chk("R7 id after early nack", id_q, 8'h00);

        // R1: reset clears an assigned ID.
        run_assign(1'b0, 8'h5A, a1, a2);
        read_ser('0, 1'b0, 6, 5, rx);
        do_stop();
        chk("R5 assign before reset", id_q, 8'h5A);
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 id after second reset", id_q, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule